// File: doc/BRIEF.md
# Oversampling Serial Receiver with Start-Up Resynchronization

This block receives asynchronous serial words on a single line whose idle level is logic 1. The line is oversampled under a tick enable that runs at 4 or 16 times the bit rate. Every frame opens with a space (logic 0) start bit lasting one bit time. The data bits follow, least significant first, and at least one bit time of mark closes the frame as the stop bit. The raw line first passes through a two-flop synchronizer. Every later decision is taken only on cycles where the tick enable is high.

A receiver that comes out of reset on a line already carrying traffic cannot tell a start bit from a zero data bit. To avoid this, a guard counts unbroken runs of one level after reset. Framing is held off until the line has stayed at mark for a full word of bit times, or at space for one bit time longer than a word. After a space lock, the receiver still waits for the line to rise to mark before it hunts for a start edge. Each received word comes out with a one-cycle valid strobe. A framing error flag is valid in the same cycle.

The oversample ratio and the word length are selected by two inputs, which are meant to be held steady while reset is asserted.

Top module: `uart_rx_resync`

## Requirements
- R1: While reset is held and on the first cycle after it, `rx_valid` and `rx_ferr` are 0 and `rx_data` is 0.
- R2: After reset, no word is framed until the synchronized line has been mark for N consecutive bit times (N times the oversample ratio ticks), where N is the word length. Falling edges before that point produce no output.
- R3: A run of N+1 consecutive bit times of space after reset also completes synchronization. The receiver then frames nothing until the line has returned to mark.
- R4: `os_sel` picks the oversample ratio: 0 gives 4 ticks per bit and 1 gives 16 ticks per bit.
- R5: `len_sel` picks the word length: 0 gives 7 data bits, returned in `rx_data[6:0]` with `rx_data[7]` = 0, and 1 gives 8 data bits. No parity bit is present.
- R6: The start bit is confirmed half a bit time after the falling edge is seen. Each later bit is sampled one bit time after the previous sample, and data bits are assembled LSB first.
- R7: A space pulse that has ended by the start-bit midpoint is discarded as a glitch. The receiver goes back to hunting and produces no word.
- R8: A stop bit sampled as space sets `rx_ferr` = 1 together with `rx_valid`. The receiver then waits for mark before it accepts another start edge. A stop bit sampled as mark gives `rx_ferr` = 0.
- R9: Each completed word, good or bad, raises `rx_valid` for exactly one clock cycle, with `rx_data` and `rx_ferr` valid in that cycle. Frames sent back to back with a single stop bit are each delivered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| os_tick | input | 1 | Oversample enable, one cycle per sub-period |
| os_sel | input | 1 | Oversample ratio select: 0 = 4x, 1 = 16x |
| len_sel | input | 1 | Word length select: 0 = 7 bits, 1 = 8 bits |
| rx_line | input | 1 | Raw asynchronous serial line, idle high |
| rx_data | output | 8 | Last received word |
| rx_valid | output | 1 | One-cycle strobe marking a completed word |
| rx_ferr | output | 1 | Framing error for the word in the same cycle |

## Verification
There are two ways a wrong run counter or lock flag shows at the ports. If the counter locks too early, a word appears where none was allowed. If it locks too late, a correctly sent frame is lost, and the missing strobe is visible within one frame time. A framer that has slipped by a bit period shows up as shifted data bits or a false framing error on the very next word. A framer that fails to leave its wait state shows up as no strobe at all by the time the stop bit has ended. The bench therefore compares each word's count, value and error flag shortly after the stop bit. It also holds quiet intervals in which no strobe may appear.

// File: rtl/uart_rx_pkg.sv
// Package: shared types for the oversampling serial receiver.
// Assumes nothing beyond a standard compile order (this file first).
package uart_rx_pkg;

    // Framer states, in the order a frame walks through them.
    typedef enum logic [2:0] {
        FR_WAIT  = 3'd0,  // waiting for lock and for the line at mark
        FR_HUNT  = 3'd1,  // line at mark, looking for a space
        FR_START = 3'd2,  // confirming the start bit at its midpoint
        FR_DATA  = 3'd3,  // sampling data bits
        FR_STOP  = 3'd4   // sampling the stop bit
    } fr_state_t;

endpackage

// File: rtl/uart_rx_sync2.sv
// Module: two-flop synchronizer for the raw serial line.
// Assumes: the input is asynchronous to clk. The reset value is the idle level,
// so no false space is seen as reset is released.
module uart_rx_sync2 #(
    parameter logic IDLE_LVL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);

    logic meta_q;

    // Pass the line through two flops to settle metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= IDLE_LVL;
            q_sync <= IDLE_LVL;
        end else begin
            meta_q <= d_async;
            q_sync <= meta_q;
        end
    end

endmodule

// File: rtl/uart_rx_guard.sv
// Module: start-up resynchronization guard.
// Counts unbroken runs of one line level in oversample ticks after reset and
// sets `locked` once a mark run reaches N bit times or a space run reaches
// N+1 bit times. Once set, `locked` stays set until the next reset.
// Assumes: os_sel and len_sel are steady outside reset.
module uart_rx_guard #(
    parameter int OS_LO = 4,
    parameter int OS_HI = 16,
    parameter int W_LO  = 7,
    parameter int W_HI  = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic os_sel,
    input  logic len_sel,
    input  logic line_s,
    output logic locked
);

    localparam int RUN_MAX = (W_HI + 1) * OS_HI;
    localparam int RUNW    = $clog2(RUN_MAX + 1);

    logic            run_lvl;
    logic [RUNW-1:0] run_cnt;
    logic [RUNW-1:0] run_nxt;
    logic [RUNW-1:0] os_v;
    logic [RUNW-1:0] nb_v;
    logic [RUNW-1:0] mark_thr;
    logic [RUNW-1:0] space_thr;
    logic            hit;

    // Work out thresholds and the run length after this tick.
    always_comb begin
        os_v      = os_sel  ? RUNW'(OS_HI) : RUNW'(OS_LO);
        nb_v      = len_sel ? RUNW'(W_HI)  : RUNW'(W_LO);
        mark_thr  = RUNW'(nb_v * os_v);
        space_thr = RUNW'((nb_v + RUNW'(1)) * os_v);
        if (line_s != run_lvl) begin
            run_nxt = RUNW'(1);
        end else if (run_cnt == RUNW'(RUN_MAX)) begin
            run_nxt = run_cnt;
        end else begin
            run_nxt = run_cnt + RUNW'(1);
        end
        hit = line_s ? (run_nxt >= mark_thr) : (run_nxt >= space_thr);
    end

    // Track the current run and latch the lock once a threshold is met.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_lvl <= 1'b1;
            run_cnt <= '0;
            locked  <= 1'b0;
        end else if (tick && !locked) begin
            run_lvl <= line_s;
            run_cnt <= run_nxt;
            if (hit) begin
                locked <= 1'b1;
            end
        end
    end

    // R2: lock never drops once it is gained.
    a_r2_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked);

    // R3: the run counter never exceeds its saturation value.
    a_r3_run_bound: assert property (@(posedge clk) disable iff (!rst_n)
        run_cnt <= RUNW'(RUN_MAX));

endmodule

// File: rtl/uart_rx_framer.sv
// Module: frame sequencer. Detects the start edge, checks it at mid-bit,
// samples data bits LSB first at bit centres, checks the stop bit and
// registers the word, strobe and error flag.
// Assumes: line_s is already synchronized. Every decision is taken on tick
// cycles. Nothing leaves the wait state before `locked` is set.
module uart_rx_framer
    import uart_rx_pkg::*;
#(
    parameter int OS_LO = 4,
    parameter int OS_HI = 16,
    parameter int W_LO  = 7,
    parameter int W_HI  = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            os_sel,
    input  logic            len_sel,
    input  logic            line_s,
    input  logic            locked,
    output logic [W_HI-1:0] rx_data,
    output logic            rx_valid,
    output logic            rx_ferr
);

    localparam int CW = $clog2(OS_HI);
    localparam int BW = $clog2(W_HI);

    fr_state_t       st;
    logic [CW-1:0]   cnt;
    logic [BW-1:0]   bidx;
    logic [W_HI-1:0] shreg;
    logic [CW-1:0]   os_last;
    logic [CW-1:0]   half_last;
    logic [BW-1:0]   bit_last;

    // Decode the mode selects into counter end points.
    always_comb begin
        os_last   = os_sel  ? CW'(OS_HI - 1)     : CW'(OS_LO - 1);
        half_last = os_sel  ? CW'(OS_HI / 2 - 1) : CW'(OS_LO / 2 - 1);
        bit_last  = len_sel ? BW'(W_HI - 1)      : BW'(W_LO - 1);
    end

    // Walk each frame from edge to stop bit and register the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= FR_WAIT;
            cnt      <= '0;
            bidx     <= '0;
            shreg    <= '0;
            rx_data  <= '0;
            rx_valid <= 1'b0;
            rx_ferr  <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            rx_ferr  <= 1'b0;
            if (tick) begin
                case (st)
                    FR_WAIT: begin
                        if (locked && line_s) begin
                            st <= FR_HUNT;
                        end
                    end
                    FR_HUNT: begin
                        if (!line_s) begin
                            st  <= FR_START;
                            cnt <= '0;
                        end
                    end
                    FR_START: begin
                        if (cnt == half_last) begin
                            cnt <= '0;
                            if (line_s) begin
                                st <= FR_HUNT;
                            end else begin
                                st   <= FR_DATA;
                                bidx <= '0;
                            end
                        end else begin
                            cnt <= cnt + CW'(1);
                        end
                    end
                    FR_DATA: begin
                        if (cnt == os_last) begin
                            cnt   <= '0;
                            shreg <= {line_s, shreg[W_HI-1:1]};
                            if (bidx == bit_last) begin
                                st <= FR_STOP;
                            end else begin
                                bidx <= bidx + BW'(1);
                            end
                        end else begin
                            cnt <= cnt + CW'(1);
                        end
                    end
                    FR_STOP: begin
                        if (cnt == os_last) begin
                            cnt      <= '0;
                            rx_valid <= 1'b1;
                            rx_ferr  <= !line_s;
                            rx_data  <= len_sel ? shreg : (shreg >> (W_HI - W_LO));
                            st       <= line_s ? FR_HUNT : FR_WAIT;
                        end else begin
                            cnt <= cnt + CW'(1);
                        end
                    end
                    default: st <= FR_WAIT;
                endcase
            end
        end
    end

    // R2: the framer stays parked until the guard reports lock.
    a_r2_hold_until_lock: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |-> (st == FR_WAIT));

    // R5: the data bit index stays within the selected word length.
    a_r5_bit_range: assert property (@(posedge clk) disable iff (!rst_n)
        (st == FR_DATA) |-> (bidx <= bit_last));

    // R9: the word strobe lasts a single cycle.
    a_r9_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R8: an error flag only ever accompanies a word strobe.
    a_r8_ferr_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ferr |-> rx_valid);

endmodule

// File: rtl/uart_rx_resync.sv
// Module: top of the oversampling serial receiver. It chains the line
// synchronizer, the start-up guard and the frame sequencer.
// Assumes: os_tick is a single-cycle enable at 4x or 16x the bit rate, and
// os_sel and len_sel change only while rst_n is low.
module uart_rx_resync #(
    parameter int OS_LO = 4,
    parameter int OS_HI = 16,
    parameter int W_LO  = 7,
    parameter int W_HI  = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            os_tick,
    input  logic            os_sel,
    input  logic            len_sel,
    input  logic            rx_line,
    output logic [W_HI-1:0] rx_data,
    output logic            rx_valid,
    output logic            rx_ferr
);

    logic line_s;
    logic locked;

    uart_rx_sync2 #(.IDLE_LVL(1'b1)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (rx_line),
        .q_sync  (line_s)
    );

    uart_rx_guard #(
        .OS_LO(OS_LO), .OS_HI(OS_HI), .W_LO(W_LO), .W_HI(W_HI)
    ) u_guard (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (os_tick),
        .os_sel  (os_sel),
        .len_sel (len_sel),
        .line_s  (line_s),
        .locked  (locked)
    );

    uart_rx_framer #(
        .OS_LO(OS_LO), .OS_HI(OS_HI), .W_LO(W_LO), .W_HI(W_HI)
    ) u_framer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (os_tick),
        .os_sel   (os_sel),
        .len_sel  (len_sel),
        .line_s   (line_s),
        .locked   (locked),
        .rx_data  (rx_data),
        .rx_valid (rx_valid),
        .rx_ferr  (rx_ferr)
    );

endmodule

// File: tb/sim_uart_rx_resync.sv
`timescale 1ns/1ps
// Bench: a vector table of frames walked by one loop, then directed tests
// for reset, lock rules, glitches, error recovery and back-to-back words.
module sim_uart_rx_resync;

    localparam int TDIV = 3;  // clocks per oversample tick

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b0;
    logic       os_sel = 1'b1;
    logic       len_sel = 1'b1;
    logic       rx_line = 1'b1;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       rx_ferr;

    int n_chk = 0;
    int n_fail = 0;
    int tcnt = 0;

    // Monitor state
    int         cap_cnt = 0;
    int         dbl = 0;
    logic       prev_v = 1'b0;
    logic [7:0] last_d = '0;
    logic [7:0] last2_d = '0;
    logic       last_f = 1'b0;
    logic       last2_f = 1'b0;

    // Vector fields: {os_sel, len_sel, good_stop, data[7:0]}
    localparam logic [10:0] VEC [8] = '{
        {1'b1, 1'b1, 1'b1, 8'hA5},
        {1'b1, 1'b1, 1'b1, 8'h00},
        {1'b1, 1'b1, 1'b1, 8'hFF},
        {1'b0, 1'b1, 1'b1, 8'h3C},
        {1'b0, 1'b0, 1'b1, 8'h55},
        {1'b1, 1'b0, 1'b1, 8'hC3},
        {1'b1, 1'b1, 1'b0, 8'h81},
        {1'b0, 1'b0, 1'b0, 8'h7E}
    };

    uart_rx_resync u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .os_tick  (os_tick),
        .os_sel   (os_sel),
        .len_sel  (len_sel),
        .rx_line  (rx_line),
        .rx_data  (rx_data),
        .rx_valid (rx_valid),
        .rx_ferr  (rx_ferr)
    );

    always #2.5 clk = ~clk;

    // Oversample tick: one clock in every TDIV, driven after the edge.
    always @(posedge clk) begin
        #1;
        tcnt    = (tcnt == TDIV - 1) ? 0 : tcnt + 1;
        os_tick = (tcnt == 0);
    end

    // Capture every strobe at the falling edge.
    always @(negedge clk) begin
        if (rx_valid) begin
            if (prev_v) dbl = dbl + 1;
            last2_d = last_d;
            last2_f = last_f;
            last_d  = rx_data;
            last_f  = rx_ferr;
            cap_cnt = cap_cnt + 1;
        end
        prev_v = rx_valid;
    end

    function automatic int bclk();
        return TDIV * (os_sel ? 16 : 4);
    endfunction

    function automatic int nbits();
        return len_sel ? 8 : 7;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic hold(input logic v, input int nb);
        rx_line = v;
        repeat (nb * bclk()) @(posedge clk);
        #1;
    endtask

    task automatic hold_clk(input logic v, input int nc);
        rx_line = v;
        repeat (nc) @(posedge clk);
        #1;
    endtask

    task automatic send(input logic [7:0] d, input logic stop_lvl);
        hold(1'b0, 1);
        for (int i = 0; i < nbits(); i++) hold(d[i], 1);
        hold(stop_lvl, 1);
        rx_line = 1'b1;
    endtask

    task automatic do_reset(input logic os, input logic len);
        @(posedge clk); #1;
        rst_n   = 1'b0;
        rx_line = 1'b1;
        os_sel  = os;
        len_sel = len;
        repeat (4) @(posedge clk);
        #1;
        rst_n = 1'b1;
    endtask

    initial begin : main
        int base;
        logic [7:0] exp_d;

        // R1: reset state
        do_reset(1'b1, 1'b1);
        @(negedge clk);
        check(rx_valid == 1'b0, "R1", "valid after reset", rx_valid, 0);
        check(rx_ferr == 1'b0, "R1", "ferr after reset", rx_ferr, 0);
        check(rx_data == 8'h00, "R1", "data after reset", rx_data, 0);
        @(posedge clk); #1;

        // Vector table: R4 ratio, R5 length, R6 bit order, R8 stop, R9 strobe
        for (int v = 0; v < 8; v++) begin
            do_reset(VEC[v][10], VEC[v][9]);
            hold(1'b1, nbits() + 1);
            base = cap_cnt;
            send(VEC[v][7:0], VEC[v][8]);
            if (!VEC[v][8]) hold(1'b0, 2);
            hold(1'b1, 2);
            exp_d = VEC[v][9] ? VEC[v][7:0] : {1'b0, VEC[v][6:0]};
            check(cap_cnt == base + 1, "R9", "word count", cap_cnt - base, 1);
            check(last_d == exp_d, "R6", "data (R4/R5 modes)", last_d, exp_d);
            check(last_f == !VEC[v][8], "R8", "ferr", last_f, !VEC[v][8]);
        end

        // R2: too little idle, then a frame: nothing framed
        do_reset(1'b1, 1'b1);
        hold(1'b1, 7);
        base = cap_cnt;
        send(8'h00, 1'b1);
        hold(1'b1, 1);
        check(cap_cnt == base, "R2", "no word before lock", cap_cnt - base, 0);
        hold(1'b1, 9);
        base = cap_cnt;
        send(8'h5A, 1'b1);
        hold(1'b1, 2);
        check(cap_cnt == base + 1 && last_d == 8'h5A, "R2", "word after lock", last_d, 8'h5A);

        // R3: long space locks, but nothing framed while space persists
        do_reset(1'b1, 1'b1);
        base = cap_cnt;
        hold(1'b0, 22);
        check(cap_cnt == base, "R3", "no word during space", cap_cnt - base, 0);
        hold(1'b1, 1);
        send(8'h96, 1'b1);
        hold(1'b1, 2);
        check(cap_cnt == base + 1 && last_d == 8'h96, "R3", "word after space lock", last_d, 8'h96);

        // R3: space run one word short does not lock
        do_reset(1'b1, 1'b1);
        base = cap_cnt;
        hold(1'b0, 7);
        hold(1'b1, 1);
        send(8'h96, 1'b1);
        hold(1'b1, 1);
        check(cap_cnt == base, "R3", "short space no lock", cap_cnt - base, 0);

        // R7: quarter-bit glitch is discarded, then a real frame is accepted
        do_reset(1'b1, 1'b1);
        hold(1'b1, 9);
        base = cap_cnt;
        hold_clk(1'b0, 4 * TDIV);
        hold(1'b1, 12);
        check(cap_cnt == base, "R7", "glitch ignored", cap_cnt - base, 0);
        send(8'h2D, 1'b1);
        hold(1'b1, 2);
        check(cap_cnt == base + 1 && last_d == 8'h2D, "R7", "frame after glitch", last_d, 8'h2D);

        // R8: framing error, line stays low, then recovery
        do_reset(1'b0, 1'b1);
        hold(1'b1, 9);
        base = cap_cnt;
        send(8'hE1, 1'b0);
        hold(1'b0, 3);
        check(cap_cnt == base + 1 && last_f == 1'b1, "R8", "error word only", cap_cnt - base, 1);
        hold(1'b1, 1);
        send(8'h6B, 1'b1);
        hold(1'b1, 2);
        check(cap_cnt == base + 2 && last_d == 8'h6B && last_f == 1'b0, "R8", "recovery word", last_d, 8'h6B);

        // R9: back-to-back frames with a single stop bit
        do_reset(1'b1, 1'b1);
        hold(1'b1, 9);
        base = cap_cnt;
        send(8'h12, 1'b1);
        send(8'h34, 1'b1);
        hold(1'b1, 2);
        check(cap_cnt == base + 2, "R9", "back-to-back count", cap_cnt - base, 2);
        check(last2_d == 8'h12 && last_d == 8'h34, "R9", "back-to-back data", {last2_d, last_d}, 16'h1234);
        check(dbl == 0, "R9", "strobe width", dbl, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #750000;
        n_fail = n_fail + 1;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule